// File: doc/BRIEF.md
# Accumulator ALU with Bit-Test Support

This block is the arithmetic and logic unit of a small accumulator-style microcontroller core. Each cycle it takes a 4-bit operation code, two 8-bit operands and the carry bit of the status word. One clock later it presents an 8-bit result, a carry-out and a zero flag. Operand selection, instruction decode, the status register and the program counter sit outside it.

The operations are add, subtract, AND, OR, XOR, complement, rotate right or left through the carry, and nibble swap. There are also single-bit clear and set, and two single-bit tests. For the bit operations, operand A carries the file value and operand B carries the raw instruction literal, whose top three bits name the bit. For the two tests, the zero flag is the skip condition that the sequencer acts on.

The decode around the ALU reuses these operations for other instructions. Increment and decrement become add and subtract with B set to 1. A clear becomes XOR of two equal operands, and a move becomes OR with a zero or identical operand. Code 1111 is issued when no operation is selected. It and the other unassigned codes produce a harmless pass-through.

Top module: `mcu_alu`

## Requirements
- R1: While rst is high at a rising clock edge, result, cout and zero are all 0 after that edge.
- R2: Outputs are registered: the values presented after a rising edge are computed from op, a, b and cin as sampled at that edge.
- R3: op 0000 (add): result = (a + b) mod 256, and cout is the carry out of bit 7.
- R4: op 0001 (subtract): result = (a - b) mod 256, and cout is 1 when a >= b unsigned (no borrow) and 0 otherwise.
- R5: op 0010 gives a AND b, 0011 gives a OR b, 0100 gives a XOR b and 0101 gives NOT a. For all four, cout equals cin.
- R6: op 0110 (rotate right) gives {cin, a[7:1]} with cout = a[0]. op 0111 (rotate left) gives {a[6:0], cin} with cout = a[7].
- R7: op 1000 (swap) gives {a[3:0], a[7:4]} with cout = cin.
- R8: op 1001 gives a with bit b[7:5] forced to 0, and op 1010 gives a with bit b[7:5] forced to 1. b[4:0] has no effect, and cout = cin.
- R9: For op 1011 (test-clear) zero is 1 exactly when a[b[7:5]] is 0. For op 1100 (test-set) zero is 1 exactly when a[b[7:5]] is 1. For both tests, result = a and cout = cin.
- R10: For every op other than 1011 and 1100, zero is 1 exactly when the 8-bit result is 0.
- R11: ops 1101, 1110 and 1111 (1111 being the idle default) give result = a and cout = cin, with zero per R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| a | input | 8 | Operand A (file value for bit operations) |
| b | input | 8 | Operand B (instruction literal for bit operations) |
| cin | input | 1 | Carry-in from the status word |
| result | output | 8 | Registered result |
| cout | output | 1 | Registered carry-out |
| zero | output | 1 | Registered zero / skip flag |

## Verification
The bench drives add and subtract at the wrap points: 255+1, 0-1, and equal operands. These points catch a subtract carry with inverted sense (borrow instead of no-borrow), or a missing carry out of bit 7. Rotates are driven with both carry-in values and with the end bits set. This catches a rotate that fills from 0 instead of the carry, or that reports the wrong end bit as carry-out. Every bit index 0 to 7 is used for set, clear and both tests, with random junk in b[4:0] and random other bits in a. This exposes an index taken from the wrong field, a test that reports the inverted skip sense, and a test that alters the result. The unassigned codes and random sweeps of all 16 codes show whether the idle default corrupts the operand or the carry.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'b0000,
    OP_SUB   = 4'b0001,
    OP_AND   = 4'b0010,
    OP_OR    = 4'b0011,
    OP_XOR   = 4'b0100,
    OP_NOT   = 4'b0101,
    OP_RRC   = 4'b0110,
    OP_RLC   = 4'b0111,
    OP_NSWAP = 4'b1000,
    OP_BCLR  = 4'b1001,
    OP_BSET  = 4'b1010,
    OP_TCLR  = 4'b1011,
    OP_TSET  = 4'b1100,
    OP_IDLE  = 4'b1111
  } alu_op_e;

endpackage

// File: rtl/mcu_alu_addsub.sv
module mcu_alu_addsub #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry
);
  // Subtract as a + ~b + 1; the carry then reads 1 when no borrow occurs.
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   total;

  assign b_eff = sub ? ~b : b;
  assign total = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum   = total[DATA_W-1:0];
  assign carry = total[DATA_W];
endmodule

// File: rtl/mcu_alu_logic.sv
module mcu_alu_logic
  import mcu_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int unsigned HALF = DATA_W / 2;

  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NOT:   res = ~a;
      OP_RRC: begin
        res  = {cin, a[DATA_W-1:1]};
        cout = a[0];
      end
      OP_RLC: begin
        res  = {a[DATA_W-2:0], cin};
        cout = a[DATA_W-1];
      end
      OP_NSWAP: res = {a[HALF-1:0], a[DATA_W-1:HALF]};
      default:  res = a;
    endcase
  end
endmodule

// File: rtl/mcu_alu_bitops.sv
module mcu_alu_bitops #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] cleared,
  output logic [DATA_W-1:0] setted,
  output logic              bit_val
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign cleared = a & ~mask;
  assign setted  = a | mask;
  assign bit_val = |(a & mask);
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout,
  output logic              zero
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam int unsigned HALF  = DATA_W / 2;

  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] as_sum, lg_res, bo_clr, bo_set;
  logic              as_carry, lg_cout, bo_bit;
  logic [DATA_W-1:0] res_d;
  logic              cout_d, zero_d;
  logic [DATA_W-1:0] res_q;
  logic              cout_q, zero_q;

  assign bidx = b[DATA_W-1 -: IDX_W];

  mcu_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(a), .b(b), .sub(op == OP_SUB), .sum(as_sum), .carry(as_carry)
  );

  mcu_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .a(a), .b(b), .cin(cin), .res(lg_res), .cout(lg_cout)
  );

  mcu_alu_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitops (
    .a(a), .idx(bidx), .cleared(bo_clr), .setted(bo_set), .bit_val(bo_bit)
  );

  always_comb begin
    res_d  = lg_res;
    cout_d = lg_cout;
    zero_d = (lg_res == '0);
    case (op)
      OP_ADD, OP_SUB: begin
        res_d  = as_sum;
        cout_d = as_carry;
        zero_d = (as_sum == '0);
      end
      OP_BCLR: begin
        res_d  = bo_clr;
        cout_d = cin;
        zero_d = (bo_clr == '0);
      end
      OP_BSET: begin
        res_d  = bo_set;
        cout_d = cin;
        zero_d = 1'b0;
      end
      OP_TCLR: begin
        res_d  = a;
        cout_d = cin;
        zero_d = ~bo_bit;
      end
      OP_TSET: begin
        res_d  = a;
        cout_d = cin;
        zero_d = bo_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cout_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      cout_q <= cout_d;
      zero_q <= zero_d;
    end
  end

  assign result = res_q;
  assign cout   = cout_q;
  assign zero   = zero_q;

  // R1: outputs cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_q == '0 && !cout_q && !zero_q));

  // R7: nibble exchange
  a_r7_swap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_NSWAP) |->
      (res_q == {$past(a[HALF-1:0]), $past(a[DATA_W-1:HALF])}));

  // R8: addressed bit forced
  a_r8_set_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_BSET) |-> res_q[$past(bidx)]);
  a_r8_clr_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_BCLR) |-> !res_q[$past(bidx)]);

  // R9: tests leave operand and carry untouched
  a_r9_test_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == OP_TCLR || $past(op) == OP_TSET)) |->
      (res_q == $past(a) && cout_q == $past(cin)));

  // R10: zero tracks the result outside the tests
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != OP_TCLR && $past(op) != OP_TSET) |->
      (zero_q == (res_q == '0)));

  // R5: logic ops hold the carry
  a_r5_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == OP_AND || $past(op) == OP_OR ||
                     $past(op) == OP_XOR || $past(op) == OP_NOT)) |->
      (cout_q == $past(cin)));
endmodule

// File: tb/mcu_alu_tb.sv
`timescale 1ns/1ps
module mcu_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op  = 4'hF;
  logic [7:0] a   = 8'h00;
  logic [7:0] b   = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] result;
  logic       cout, zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit         have_exp = 0;
  int         exp_res, exp_c, exp_z, exp_op;

  always #2.5 clk = ~clk;

  mcu_alu u_dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .cin(cin),
    .result(result), .cout(cout), .zero(zero)
  );

  function automatic string tag(input int o);
    case (o)
      0:  return "R3";
      1:  return "R4";
      2, 3, 4, 5: return "R5";
      6, 7: return "R6";
      8:  return "R7";
      9, 10: return "R8";
      11, 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference, written from the requirements
  task automatic model(input int o, input int x, input int y, input int c,
                       output int r, output int co, output int z);
    int k;
    k  = y / 32;
    r  = x;
    co = c;
    case (o)
      0: begin r = (x + y) % 256; co = (x + y) > 255; end
      1: begin r = (x - y + 256) % 256; co = (x >= y); end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: r = 255 - x;
      6: begin r = c * 128 + x / 2; co = x % 2; end
      7: begin r = (x * 2) % 256 + c; co = x / 128; end
      8: r = (x % 16) * 16 + x / 16;
      9: r = x & (255 - (1 << k));
      10: r = x | (1 << k);
      default: r = x;
    endcase
    if (o == 11)      z = (((x >> k) & 1) == 0);
    else if (o == 12) z = (((x >> k) & 1) == 1);
    else              z = (r == 0);
  endtask

  task automatic compare();
    checks++;
    if (result !== exp_res[7:0] || cout !== exp_c[0] || zero !== exp_z[0]) begin
      fails++;
      $display("FAIL %s/R2/R10 op=%0d: got res=%02h c=%0b z=%0b, expected res=%02h c=%0b z=%0b",
               tag(exp_op), exp_op, result, cout, zero, exp_res[7:0], exp_c[0], exp_z[0]);
    end
  endtask

  task automatic step(input int o, input int x, input int y, input int c);
    int r, co, z;
    @(negedge clk);
    if (have_exp) compare();
    op  = o[3:0];
    a   = x[7:0];
    b   = y[7:0];
    cin = c[0];
    model(o, x, y, c, r, co, z);
    exp_res = r; exp_c = co; exp_z = z; exp_op = o;
    have_exp = 1;
  endtask

  initial begin
    // R1: reset with busy inputs
    op = 4'h0; a = 8'hFF; b = 8'h01; cin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== 8'h00 || cout !== 1'b0 || zero !== 1'b0) begin
      fails++;
      $display("FAIL R1: got res=%02h c=%0b z=%0b, expected res=00 c=0 z=0",
               result, cout, zero);
    end
    rst = 1'b0;

    // R3 / R4 wrap points
    step(0, 255, 1, 0);
    step(0, 200, 100, 1);
    step(0, 0, 0, 1);
    step(1, 0, 1, 0);
    step(1, 77, 77, 0);
    step(1, 100, 3, 0);
    step(0, 5, 1, 0);   // increment form
    step(1, 1, 1, 1);   // decrement to zero
    // R5 clear and move idioms
    step(4, 99, 99, 1);
    step(3, 0, 42, 0);
    step(5, 255, 0, 1);
    // R6 rotates, both carry values and end bits
    step(6, 1, 0, 0);
    step(6, 1, 0, 1);
    step(6, 128, 0, 1);
    step(7, 128, 0, 0);
    step(7, 1, 0, 1);
    step(7, 0, 0, 1);
    // R7 swap
    step(8, 8'hA5, 0, 1);
    step(8, 0, 0, 0);
    // R8 / R9 every bit index with junk low literal bits
    for (int k = 0; k < 8; k++) begin
      for (int rep = 0; rep < 4; rep++) begin
        int lit, av;
        lit = k * 32 + int'($urandom_range(0, 31));
        av  = int'($urandom_range(0, 255));
        step(9, av, lit, rep % 2);
        step(10, av, lit, rep % 2);
        step(11, av, lit, rep % 2);
        step(12, av, lit, rep % 2);
        step(11, av | (1 << k), lit, 0);
        step(12, av & (255 - (1 << k)), lit, 1);
      end
    end
    step(9, 1, 0, 0);
    // R11 unassigned and idle codes
    step(13, 8'h3C, 8'hFF, 1);
    step(14, 0, 8'hFF, 1);
    step(15, 8'h81, 8'h55, 0);
    step(15, 0, 8'h55, 1);
    // random sweep of all codes
    for (int n = 0; n < 3000; n++) begin
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule